// File: doc/BRIEF.md
# Received Word Half-Word Readout Port

This block holds the most recent 32-bit word delivered by a serial receiver and hands it to a host over a 16-bit shared data bus in two halves. The host pulls an active-low read strobe; while it is low the block drives the bus (modelled as data plus an output enable). A select line picks the half: low gives bits 15:0, high gives bits 31:16. The active-low ready flag drops when a word arrives and rises again only when a read made with select high ends, so reading the low half alone never releases the word.

The block also supports repeater forwarding. If the host raises the first transmit load strobe together with the end of a read, the half on the bus is held. If it then raises the second load strobe together with the end of a later read, the block emits a 31-bit word made of the held low half and the current half minus its top bit. This is the received word with its parity bit removed, ready for the transmit FIFO. A word that arrives before the previous one was fully read replaces it and raises an overrun flag.

The receive input is a valid/ready stream whose ready is always high: the block never back-pressures and a new word always overwrites the buffer. The transmit output is a one-cycle valid pulse with no ready. The FIFO must take the word in the cycle it is offered. All pins are synchronous to `clk`.

Top module: `hb_readout_port`

## Requirements
- R1: After reset, ready flag `rdy_n` is 1, `ovr` is 0, `bus_oe` is 0 and `tx_valid` is 0.
- R2: A cycle with `rx_valid` high stores `rx_word`, and `rdy_n` is 0 from the next cycle. `rx_ready` is always 1.
- R3: `bus_oe` is 1 exactly while `rd_n` is 0.
- R4: While driving, `bus_data` is word bits 15:0 when `sel` is 0 and bits 31:16 when `sel` is 1.
- R5: When `rd_n` rises after a read whose last low cycle had `sel` at 1, `rdy_n` becomes 1 in the next cycle. A read with `sel` at 0 leaves `rdy_n` at 0.
- R6: A word arriving while `rdy_n` is 0 replaces the stored word and sets `ovr`. `ovr` clears when a read with `sel` at 1 completes.
- R7: If a word arrives in the same cycle that a read with `sel` at 1 completes, the new word is kept and `rdy_n` stays 0.
- R8: A rising `pl1_n` during a read (`rd_n` low in the prior cycle) holds the bus half. A later rising `pl2_n` during a read raises `tx_valid` for exactly one cycle, with `tx_data` = {current half bits 14:0, held half}. Bit 15 of the second half, which is the received parity bit 31, is dropped.
- R9: Load strobe rises when `rd_n` was high in the prior cycle have no effect. A `pl2_n` rise with no held half since the last emitted word produces no `tx_valid`.
- R10: Repeated `pl1_n` captures before `pl2_n` overwrite the held half, so the last one wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | Received word offered |
| rx_word | input | 32 | Received word including parity bit 31 |
| rx_ready | output | 1 | Always 1; the block never stalls the receiver |
| rd_n | input | 1 | Active-low read strobe |
| sel | input | 1 | Half select: 0 low half, 1 high half |
| pl1_n | input | 1 | Active-low first transmit load strobe |
| pl2_n | input | 1 | Active-low second transmit load strobe |
| bus_data | output | 16 | Half-word for the shared bus |
| bus_oe | output | 1 | Bus output enable |
| rdy_n | output | 1 | Active-low word-ready flag |
| ovr | output | 1 | Overrun indicator |
| tx_valid | output | 1 | One-cycle pulse: forwarded word available |
| tx_data | output | 31 | Forwarded word with parity removed |

## Verification
The hardest situation to reach from the pins is a new word landing in exactly the cycle that a high-half read completes, where clearing the flag and setting it compete. The bench ends the second read and raises `rx_valid` in the same drive step, so both reach the same clock edge. It then reads the buffer back to show that the newer word survived. Repeater ordering is driven the same way: load strobes are raised together with read ends, and stray strobes are placed outside any read.

// File: rtl/hb_readout_pkg.sv
package hb_readout_pkg;
  localparam int unsigned STROBES = 3;
  localparam int unsigned IDX_RD  = 0;
  localparam int unsigned IDX_PL1 = 1;
  localparam int unsigned IDX_PL2 = 2;

  typedef struct packed {
    logic pl2;
    logic pl1;
    logic rd;
  } strobe_t;
endpackage

// File: rtl/strobe_track.sv
module strobe_track #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl_n,
  output logic [N-1:0] prev_n
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_n[i] <= 1'b1;
      else        prev_n[i] <= lvl_n[i];
    end
  end
endmodule

// File: rtl/rx_word_buf.sv
module rx_word_buf #(
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [WORD_W-1:0] rx_word,
  input  logic              sel,
  input  logic              rd_low,
  input  logic              rd_rise,
  output logic [WORD_W-1:0] word_q,
  output logic              sel_lat,
  output logic              rdy_n,
  output logic              ovr
);
  logic complete;
  assign complete = rd_rise & sel_lat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q  <= '0;
      sel_lat <= 1'b0;
      rdy_n   <= 1'b1;
      ovr     <= 1'b0;
    end else begin
      if (rd_low) sel_lat <= sel;
      if (rx_valid) begin
        word_q <= rx_word;
        rdy_n  <= 1'b0;
      end else if (complete) begin
        rdy_n <= 1'b1;
      end
      if (rx_valid && !rdy_n) ovr <= 1'b1;
      else if (complete)      ovr <= 1'b0;
    end
  end

  a_r2_flag_on_arrival: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rdy_n);
  a_r5_flag_release: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rise && sel_lat && !rx_valid) |=> rdy_n);
  a_r6_overrun_set: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rdy_n) |=> ovr);
endmodule

// File: rtl/repeater_cap.sv
module repeater_cap #(
  parameter int unsigned HALF_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pl1_rise,
  input  logic                pl2_rise,
  input  logic                in_read,
  input  logic [HALF_W-1:0]   half,
  output logic                tx_valid,
  output logic [2*HALF_W-2:0] tx_data
);
  logic              have_lo;
  logic [HALF_W-1:0] lo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_lo  <= 1'b0;
      lo_q     <= '0;
      tx_valid <= 1'b0;
      tx_data  <= '0;
    end else begin
      tx_valid <= 1'b0;
      if (in_read && pl2_rise && have_lo) begin
        tx_data  <= {half[HALF_W-2:0], lo_q};
        tx_valid <= 1'b1;
        have_lo  <= 1'b0;
      end else if (in_read && pl1_rise) begin
        lo_q    <= half;
        have_lo <= 1'b1;
      end
    end
  end

  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |=> !tx_valid);
  a_r10_hold_after_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (in_read && pl1_rise && !pl2_rise) |=> have_lo);
endmodule

// File: rtl/hb_readout_port.sv
module hb_readout_port #(
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [WORD_W-1:0] rx_word,
  output logic              rx_ready,
  input  logic              rd_n,
  input  logic              sel,
  input  logic              pl1_n,
  input  logic              pl2_n,
  output logic [WORD_W/2-1:0] bus_data,
  output logic              bus_oe,
  output logic              rdy_n,
  output logic              ovr,
  output logic              tx_valid,
  output logic [WORD_W-2:0] tx_data
);
  import hb_readout_pkg::*;
  localparam int unsigned HALF_W = WORD_W / 2;

  strobe_t           lvl, prev;
  logic [STROBES-1:0] rise;
  logic [WORD_W-1:0] word_q;
  logic              sel_lat;
  logic [HALF_W-1:0] cap_half;

  assign lvl = '{pl2: pl2_n, pl1: pl1_n, rd: rd_n};

  strobe_track #(.N(STROBES)) u_track (
    .clk(clk), .rst_n(rst_n), .lvl_n(lvl), .prev_n(prev)
  );

  for (genvar i = 0; i < STROBES; i++) begin : g_rise
    assign rise[i] = lvl[i] & ~prev[i];
  end

  rx_word_buf #(.WORD_W(WORD_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_word(rx_word),
    .sel(sel), .rd_low(~rd_n), .rd_rise(rise[IDX_RD]),
    .word_q(word_q), .sel_lat(sel_lat), .rdy_n(rdy_n), .ovr(ovr)
  );

  assign cap_half = sel_lat ? word_q[WORD_W-1:HALF_W] : word_q[HALF_W-1:0];

  repeater_cap #(.HALF_W(HALF_W)) u_rep (
    .clk(clk), .rst_n(rst_n), .pl1_rise(rise[IDX_PL1]), .pl2_rise(rise[IDX_PL2]),
    .in_read(~prev.rd), .half(cap_half), .tx_valid(tx_valid), .tx_data(tx_data)
  );

  assign rx_ready = 1'b1;
  assign bus_oe   = ~rd_n;
  assign bus_data = sel ? word_q[WORD_W-1:HALF_W] : word_q[HALF_W-1:0];

  a_r9_forward_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> ($past(rd_n, 2) == 1'b0));
  a_r7_arrival_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rd_n == 1'b0 && rise[IDX_RD]) |=> !rdy_n);
endmodule

// File: tb/tb_hb_readout_port.sv
module tb_hb_readout_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_valid = 1'b0;
  logic [31:0] rx_word = '0;
  logic        rx_ready;
  logic        rd_n = 1'b1, sel = 1'b0, pl1_n = 1'b1, pl2_n = 1'b1;
  logic [15:0] bus_data;
  logic        bus_oe, rdy_n, ovr, tx_valid;
  logic [30:0] tx_data;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  hb_readout_port dut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_word(rx_word),
    .rx_ready(rx_ready), .rd_n(rd_n), .sel(sel), .pl1_n(pl1_n), .pl2_n(pl2_n),
    .bus_data(bus_data), .bus_oe(bus_oe), .rdy_n(rdy_n), .ovr(ovr),
    .tx_valid(tx_valid), .tx_data(tx_data)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [31:0] w);
    rx_valid = 1'b1; rx_word = w;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  // one read: strobe low one cycle, then raised (with any load strobes)
  task automatic rd_half(input logic s, input logic p1, input logic p2,
                         input logic [15:0] exp_bus, input string tag);
    sel = s; rd_n = 1'b0;
    if (p1) pl1_n = 1'b0;
    if (p2) pl2_n = 1'b0;
    #1;
    chk({"R3 oe ", tag}, 32'(bus_oe), 32'd1);
    chk({"R4 bus ", tag}, 32'(bus_data), 32'(exp_bus));
    @(negedge clk);
    rd_n = 1'b1; pl1_n = 1'b1; pl2_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 rdy_n", 32'(rdy_n), 32'd1);
    chk("R1 ovr", 32'(ovr), 32'd0);
    chk("R1 oe", 32'(bus_oe), 32'd0);
    chk("R1 tx_valid", 32'(tx_valid), 32'd0);
  endtask

  task automatic t_basic;
    push(32'hA5A5_1234);
    chk("R2 rdy_n low", 32'(rdy_n), 32'd0);
    chk("R2 rx_ready", 32'(rx_ready), 32'd1);
    rd_half(1'b0, 1'b0, 1'b0, 16'h1234, "low");
    chk("R5 low half keeps flag", 32'(rdy_n), 32'd0);
    rd_half(1'b1, 1'b0, 1'b0, 16'hA5A5, "high");
    chk("R5 flag released", 32'(rdy_n), 32'd1);
    chk("R3 oe off", 32'(bus_oe), 32'd0);
    sel = 1'b0;
  endtask

  task automatic t_overrun;
    push(32'h1111_2222);
    push(32'h3333_4444);
    chk("R6 ovr set", 32'(ovr), 32'd1);
    rd_half(1'b0, 1'b0, 1'b0, 16'h4444, "R6 low");
    rd_half(1'b1, 1'b0, 1'b0, 16'h3333, "R6 high");
    chk("R6 ovr cleared", 32'(ovr), 32'd0);
    chk("R6 flag released", 32'(rdy_n), 32'd1);
    sel = 1'b0;
  endtask

  task automatic t_collision;
    push(32'hDEAD_BEEF);
    rd_half(1'b0, 1'b0, 1'b0, 16'hBEEF, "R7 low");
    sel = 1'b1; rd_n = 1'b0;
    @(negedge clk);
    rd_n = 1'b1; rx_valid = 1'b1; rx_word = 32'h0BAD_F00D;
    @(negedge clk);
    rx_valid = 1'b0;
    chk("R7 flag stays low", 32'(rdy_n), 32'd0);
    rd_half(1'b0, 1'b0, 1'b0, 16'hF00D, "R7 new low");
    rd_half(1'b1, 1'b0, 1'b0, 16'h0BAD, "R7 new high");
    chk("R7 flag released", 32'(rdy_n), 32'd1);
    sel = 1'b0;
  endtask

  task automatic t_repeater;
    push(32'hC234_5678);
    rd_half(1'b0, 1'b1, 1'b0, 16'h5678, "R8 low");
    chk("R8 no pulse after pl1", 32'(tx_valid), 32'd0);
    rd_half(1'b1, 1'b0, 1'b1, 16'hC234, "R8 high");
    chk("R8 tx_valid", 32'(tx_valid), 32'd1);
    chk("R8 tx_data", 32'(tx_data), 32'h4234_5678);
    @(negedge clk);
    chk("R8 one cycle", 32'(tx_valid), 32'd0);
    sel = 1'b0;
  endtask

  task automatic t_ignored;
    pl1_n = 1'b0; @(negedge clk); pl1_n = 1'b1; @(negedge clk);
    pl2_n = 1'b0; @(negedge clk); pl2_n = 1'b1; @(negedge clk);
    chk("R9 stray pl2", 32'(tx_valid), 32'd0);
    @(negedge clk);
    chk("R9 stray pl2 later", 32'(tx_valid), 32'd0);
    push(32'h7777_8888);
    rd_half(1'b1, 1'b0, 1'b1, 16'h7777, "R9 pl2 only");
    chk("R9 pl2 without held half", 32'(tx_valid), 32'd0);
    @(negedge clk);
    chk("R9 pl2 without held half later", 32'(tx_valid), 32'd0);
    sel = 1'b0;
  endtask

  task automatic t_overwrite;
    push(32'h8765_4321);
    rd_half(1'b1, 1'b1, 1'b0, 16'h8765, "R10 first pl1");
    rd_half(1'b0, 1'b1, 1'b0, 16'h4321, "R10 second pl1");
    rd_half(1'b1, 1'b0, 1'b1, 16'h8765, "R10 pl2");
    chk("R10 tx_valid", 32'(tx_valid), 32'd1);
    chk("R10 last pl1 wins", 32'(tx_data), 32'h0765_4321);
    sel = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_basic;
    t_overrun;
    t_collision;
    t_repeater;
    t_ignored;
    t_overwrite;
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog all actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule